// File: doc/BRIEF.md
# Active Region Crop with Frame-Synchronous Update

This block sits in a pixel stream and decides, pixel by pixel, whether each incoming valid pixel belongs to a programmable rectangular window of the frame. It keeps a column and a row position for every accepted pixel, compares that position with the window bounds, and raises an output valid only for pixels inside the window. The first pixel inside the window in each frame is also flagged as the start of the output frame. Downstream logic therefore sees a smaller frame, complete with its own frame-start marker.

The window is described by the coordinates of its upper-left pixel and by its width and height, each given as the count minus one. The frame width and height are also runtime inputs. The block copies all six values into shadow registers on the pixel that starts a frame. That pixel, and every later pixel of the same frame, is judged against the copy. Changes to the live inputs in the middle of a frame therefore have no effect until the next frame starts. A one-cycle pulse reports each copy, so a pending-update flag elsewhere can be cleared.

Any part of the window that lies outside the frame is clipped away. A pixel is accepted only when its input valid is high and a frame has started since reset. The block has one cycle of latency: it registers all outputs one clock after the pixel is presented.

Top module: `roi_crop`

## Requirements
- R1: After reset, and while reset is high, all three outputs are low. Valid pixels that arrive before the first frame-start pixel (pix_vld_i and sof_i both high) are ignored and never raise out_vld_o.
- R2: The frame-start pixel is at column 0, row 0. After each accepted pixel, the column advances by one. After the pixel in column frm_w_i-1, the column returns to 0 and the row advances by one.
- R3: out_vld_o is high in the cycle after an accepted pixel exactly when org_x ≤ column ≤ org_x+ext_w_m1 and org_y ≤ row ≤ org_y+ext_h_m1, with both bounds inclusive. It is low in the cycle after any cycle in which pix_vld_i is low.
- R4: Pixels at a column ≥ frame width or a row ≥ frame height never raise out_vld_o. This holds even when the window extends past those edges, so that a window reaching over the right or bottom edge is clipped.
- R5: out_sof_o is high, together with out_vld_o, for the first in-window pixel of a frame only, which is the window origin. It is high at most once per frame, and never in a frame whose window lies wholly outside the frame.
- R6: Frame width and height, origin, and the two extents are sampled on the frame-start pixel and govern that pixel and the rest of the frame. Changes on those inputs mid-frame take effect only at the next frame-start pixel.
- R7: cfg_taken_o is high for exactly one cycle, the cycle after each frame-start pixel, and low otherwise.
- R8: sof_i high while pix_vld_i is low has no effect. It does not restart the counters, capture the inputs, or pulse cfg_taken_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld_i | input | 1 | Input pixel valid |
| sof_i | input | 1 | Marks the first pixel of a frame (qualified by pix_vld_i) |
| frm_w_i | input | COORD_W | Frame width in pixels |
| frm_h_i | input | COORD_W | Frame height in rows |
| org_x_i | input | COORD_W | Window origin column |
| org_y_i | input | COORD_W | Window origin row |
| ext_w_m1_i | input | COORD_W | Window width minus one |
| ext_h_m1_i | input | COORD_W | Window height minus one |
| out_vld_o | output | 1 | Pixel lies inside the window |
| out_sof_o | output | 1 | First in-window pixel of the frame |
| cfg_taken_o | output | 1 | Shadow registers loaded from the live inputs |

## Verification
The bench uses several windows: an interior window, a window covering the full frame, a single-pixel window in the bottom-right corner, a window clipped at the right and bottom edges, and a window entirely off-frame. A design with an off-by-one in the minus-one extents, or in the column wrap, would misplace the window edge or shift every later row. A design that did not clip would emit valids for rows sent past the frame height. The bench changes the live window in the middle of a frame; a design that did not shadow the values would crop the rest of that frame with the new values. Stray frame-start strobes without a valid are mixed into the stream; a design that honoured them would restart its counters and pulse cfg_taken_o.

// File: rtl/roi_pkg.sv
`timescale 1ns/1ps
package roi_pkg;

    // Coordinate width: covers frames up to 2047 pixels on a side.
    parameter int unsigned COORD_W = 11;

    typedef logic [COORD_W-1:0] coord_t;

    // Window and frame settings, live or shadowed.
    typedef struct packed {
        coord_t frm_w;
        coord_t frm_h;
        coord_t org_x;
        coord_t org_y;
        coord_t ext_w_m1;
        coord_t ext_h_m1;
    } roi_cfg_t;

    // Position of the pixel presented this cycle.
    typedef struct packed {
        logic   ok;
        coord_t col;
        coord_t row;
    } pix_pos_t;

    // Inclusive span test with a one-bit-wider upper bound, so the sum cannot overflow.
    function automatic logic in_span(coord_t pos, coord_t lo, coord_t ext_m1);
        logic [COORD_W:0] hi;
        hi = {1'b0, lo} + {1'b0, ext_m1};
        return (pos >= lo) && ({1'b0, pos} <= hi);
    endfunction

    // Increment that holds at the top value.
    function automatic coord_t sat_inc(coord_t v);
        coord_t one;
        one = coord_t'(1);
        return (v == '1) ? v : v + one;
    endfunction

endpackage

// File: rtl/roi_shadow.sv
`timescale 1ns/1ps
module roi_shadow
    import roi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take_i,
    input  roi_cfg_t live_i,
    output roi_cfg_t eff_o
);

    roi_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (take_i) begin
            cfg_q <= live_i;
        end
    end

    // The frame-start pixel already uses the values it captures.
    assign eff_o = take_i ? live_i : cfg_q;

endmodule

// File: rtl/roi_pos_cnt.sv
`timescale 1ns/1ps
module roi_pos_cnt
    import roi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     vld_i,
    input  logic     sof_i,
    input  coord_t   frm_w_i,
    output pix_pos_t pos_o
);

    localparam coord_t ONE = coord_t'(1);

    logic   armed_q;
    coord_t col_q;
    coord_t row_q;
    logic   take;

    assign take = vld_i && sof_i;

    always_comb begin
        pos_o.ok  = vld_i && (take || armed_q);
        pos_o.col = take ? '0 : col_q;
        pos_o.row = take ? '0 : row_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            col_q   <= '0;
            row_q   <= '0;
        end else if (pos_o.ok) begin
            armed_q <= 1'b1;
            if (pos_o.col >= frm_w_i - ONE) begin
                col_q <= '0;
                row_q <= sat_inc(pos_o.row);
            end else begin
                col_q <= pos_o.col + ONE;
                row_q <= pos_o.row;
            end
        end
    end

endmodule

// File: rtl/roi_window_cmp.sv
`timescale 1ns/1ps
module roi_window_cmp
    import roi_pkg::*;
(
    input  pix_pos_t pos_i,
    input  roi_cfg_t cfg_i,
    output logic     hit_o
);

    logic in_frame;
    logic in_cols;
    logic in_rows;

    always_comb begin
        in_frame = (pos_i.col < cfg_i.frm_w) && (pos_i.row < cfg_i.frm_h);
        in_cols  = in_span(pos_i.col, cfg_i.org_x, cfg_i.ext_w_m1);
        in_rows  = in_span(pos_i.row, cfg_i.org_y, cfg_i.ext_h_m1);
        hit_o    = pos_i.ok && in_frame && in_cols && in_rows;
    end

endmodule

// File: rtl/roi_crop.sv
`timescale 1ns/1ps
module roi_crop
    import roi_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pix_vld_i,
    input  logic                       sof_i,
    input  logic [roi_pkg::COORD_W-1:0] frm_w_i,
    input  logic [roi_pkg::COORD_W-1:0] frm_h_i,
    input  logic [roi_pkg::COORD_W-1:0] org_x_i,
    input  logic [roi_pkg::COORD_W-1:0] org_y_i,
    input  logic [roi_pkg::COORD_W-1:0] ext_w_m1_i,
    input  logic [roi_pkg::COORD_W-1:0] ext_h_m1_i,
    output logic                       out_vld_o,
    output logic                       out_sof_o,
    output logic                       cfg_taken_o
);

    roi_cfg_t live;
    roi_cfg_t eff;
    pix_pos_t pos;
    logic     take;
    logic     hit;
    logic     pend_q;
    logic     pend_cur;

    assign take = pix_vld_i && sof_i;

    always_comb begin
        live.frm_w    = frm_w_i;
        live.frm_h    = frm_h_i;
        live.org_x    = org_x_i;
        live.org_y    = org_y_i;
        live.ext_w_m1 = ext_w_m1_i;
        live.ext_h_m1 = ext_h_m1_i;
    end

    roi_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .take_i (take),
        .live_i (live),
        .eff_o  (eff)
    );

    roi_pos_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (pix_vld_i),
        .sof_i   (sof_i),
        .frm_w_i (eff.frm_w),
        .pos_o   (pos)
    );

    roi_window_cmp u_cmp (
        .pos_i (pos),
        .cfg_i (eff),
        .hit_o (hit)
    );

    // Output frame start is still owed for this frame.
    assign pend_cur = take ? 1'b1 : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            out_vld_o   <= 1'b0;
            out_sof_o   <= 1'b0;
            cfg_taken_o <= 1'b0;
        end else begin
            pend_q      <= pend_cur && !hit;
            out_vld_o   <= hit;
            out_sof_o   <= hit && pend_cur;
            cfg_taken_o <= take;
        end
    end

endmodule

// File: rtl/roi_crop_chk.sv
`timescale 1ns/1ps
module roi_crop_chk (
    input logic clk,
    input logic rst,
    input logic pix_vld_i,
    input logic sof_i,
    input logic out_vld_o,
    input logic out_sof_o,
    input logic cfg_taken_o
);

    logic armed_q;
    logic sof_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            sof_seen_q <= 1'b0;
        end else begin
            if (pix_vld_i && sof_i) armed_q <= 1'b1;
            if (out_sof_o) sof_seen_q <= 1'b1;
            else if (cfg_taken_o) sof_seen_q <= 1'b0;
        end
    end

    a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !(pix_vld_i && sof_i)) |=> !out_vld_o);

    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !pix_vld_i |=> !out_vld_o);

    a_r5_sof_has_valid: assert property (@(posedge clk) disable iff (rst)
        out_sof_o |-> out_vld_o);

    a_r5_one_sof_per_frame: assert property (@(posedge clk) disable iff (rst)
        out_sof_o |-> (!sof_seen_q || cfg_taken_o));

    a_r7_take_pulse: assert property (@(posedge clk) disable iff (rst)
        (pix_vld_i && sof_i) |=> cfg_taken_o);

    a_r8_no_take_without_valid: assert property (@(posedge clk) disable iff (rst)
        !(pix_vld_i && sof_i) |=> !cfg_taken_o);

endmodule

bind roi_crop roi_crop_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_vld_i   (pix_vld_i),
    .sof_i       (sof_i),
    .out_vld_o   (out_vld_o),
    .out_sof_o   (out_sof_o),
    .cfg_taken_o (cfg_taken_o)
);

// File: tb/roi_crop_tb.sv
`timescale 1ns/1ps
module roi_crop_tb;
    import roi_pkg::*;

    // Each row: frame width, frame height, origin x, origin y, width-1, height-1
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{8, 5, 2, 1, 3, 2},   // interior window
        '{8, 5, 0, 0, 7, 4},   // full frame
        '{6, 4, 4, 2, 5, 5},   // clipped at right and bottom
        '{7, 6, 6, 5, 0, 0},   // single pixel, bottom-right corner
        '{5, 3, 9, 0, 1, 1},   // wholly outside the frame
        '{10, 4, 1, 3, 2, 0}   // last row only
    };

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   vld = 1'b0;
    logic   sof = 1'b0;
    coord_t fw, fh, ox, oy, ew, eh;
    logic   out_vld, out_sof, taken;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    roi_crop u_dut (
        .clk         (clk),
        .rst         (rst),
        .pix_vld_i   (vld),
        .sof_i       (sof),
        .frm_w_i     (fw),
        .frm_h_i     (fh),
        .org_x_i     (ox),
        .org_y_i     (oy),
        .ext_w_m1_i  (ew),
        .ext_h_m1_i  (eh),
        .out_vld_o   (out_vld),
        .out_sof_o   (out_sof),
        .cfg_taken_o (taken)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int i);
        fw = coord_t'(VEC[i][0]);
        fh = coord_t'(VEC[i][1]);
        ox = coord_t'(VEC[i][2]);
        oy = coord_t'(VEC[i][3]);
        ew = coord_t'(VEC[i][4]);
        eh = coord_t'(VEC[i][5]);
    endtask

    // Drive at a falling edge; outputs are then sampled at the next falling edge.
    task automatic step(bit v, bit s);
        vld = v;
        sof = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit model(int i, int c, int r);
        return (c < VEC[i][0]) && (r < VEC[i][1]) &&
               (c >= VEC[i][2]) && (c <= VEC[i][2] + VEC[i][4]) &&
               (r >= VEC[i][3]) && (r <= VEC[i][3] + VEC[i][5]);
    endfunction

    // One frame under vector i; the live inputs may switch to vector chg_i after chg_at pixels.
    task automatic run_frame(int i, int chg_at, int chg_i, int extra_rows, string tag);
        int k;
        bit first;
        k = 0;
        first = 1'b1;
        for (int r = 0; r < VEC[i][1] + extra_rows; r++) begin
            for (int c = 0; c < VEC[i][0]; c++) begin
                bit e;
                bit s0;
                e  = model(i, c, r);
                s0 = (r == 0) && (c == 0);
                step(1'b1, s0);
                chk(tag, $sformatf("R2/R3 valid at c%0d r%0d", c, r), int'(out_vld), int'(e));
                chk("R5", $sformatf("frame start at c%0d r%0d", c, r), int'(out_sof), int'(e && first));
                chk("R7", "cfg_taken pulse", int'(taken), int'(s0));
                if (e) first = 1'b0;
                k++;
                if (k == chg_at) set_cfg(chg_i);
                if (k % 7 == 0) begin
                    step(1'b0, 1'b1);
                    chk("R8", "valid on stray sof", int'(out_vld), 0);
                    chk("R8", "cfg_taken on stray sof", int'(taken), 0);
                end
            end
        end
    endtask

    initial begin
        set_cfg(1);
        @(negedge clk);
        repeat (3) step(1'b1, 1'b1);
        chk("R1", "valid in reset", int'(out_vld), 0);
        chk("R1", "sof in reset", int'(out_sof), 0);
        chk("R1", "taken in reset", int'(taken), 0);
        rst = 1'b0;
        vld = 1'b0;
        sof = 1'b0;
        step(1'b0, 1'b0);

        // Pixels with no frame start yet: full-frame window would hit, must not.
        for (int n = 0; n < 5; n++) begin
            step(1'b1, 1'b0);
            chk("R1", "valid before first frame", int'(out_vld), 0);
        end

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            set_cfg(i);
            run_frame(i, -1, 0, 0, "R3");
        end

        // Mid-frame change of the live window: rest of the frame keeps old values.
        set_cfg(0);
        run_frame(0, 12, 1, 0, "R6");
        run_frame(1, -1, 0, 0, "R6");

        // Rows sent beyond the frame height with a window that spills over.
        set_cfg(2);
        run_frame(2, -1, 0, 2, "R4");

        // Reset mid-stream disarms the block again.
        set_cfg(1);
        rst = 1'b1;
        step(1'b1, 1'b0);
        rst = 1'b0;
        step(1'b1, 1'b0);
        chk("R1", "valid after reset without frame start", int'(out_vld), 0);
        chk("R1", "sof after reset", int'(out_sof), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule